// File: doc/BRIEF.md
# Vertex-Index Result Cache

This block sits in front of a vertex shading stage and remembers the shaded output attributes of recently seen vertices, keyed by their 16-bit vertex index. Each lookup searches all entries at once. When the index is present, the stored attributes come back with a hit flag and the shading work for that vertex can be skipped entirely. When it is absent, a miss response tells the surrounding logic to send the vertex through the shader. The returned result is then installed through the fill port.

On a miss the cache picks the victim entry straight away and marks it as waiting for its fill. The victim is a free entry if one exists, and otherwise the entry whose last reference lies furthest in the past. A later lookup for a vertex that is still being shaded is held off until the fill lands, so the same vertex is never shaded twice. A flush input empties the whole cache in one cycle.

Top module: `vtx_result_cache`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, every entry is empty, so a following lookup misses. While `flush` is high, `lk_ready` is 0.
- R2: An accepted lookup (`lk_valid` and `lk_ready` high at a clock edge) gives `rsp_valid`=1 in the next cycle, with `rsp_index` equal to the looked-up index. On a hit, `rsp_hit`=1 and `rsp_data` equals the payload of the most recent fill for that index.
- R3: A lookup of an index that is absent gives `rsp_hit`=0 and `rsp_data`=0. It reserves an entry for that index, which then waits for its fill.
- R4: A lookup whose index matches an entry that is waiting for its fill sees `lk_ready`=0 until the fill for that index is taken. After that, the lookup hits.
- R5: A fill whose index matches no waiting entry is ignored. A later lookup of that index misses.
- R6: While any entry is neither valid nor waiting, a miss takes such an entry and evicts nothing. After a flush, 32 distinct indices can be installed and all 32 then hit.
- R7: When no free entry remains, a miss evicts the valid entry whose last reference is the oldest. Each hit, miss reservation and fill counts as a reference that makes its entry the newest.
- R8: A fill takes priority over a lookup. While `fill_valid` is high, `lk_ready` is 0.
- R9: When every entry is waiting for a fill, a lookup that would miss sees `lk_ready`=0 until some entry gets its fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request present |
| lk_index | input | IDX_W | Vertex index to look up |
| lk_ready | output | 1 | Lookup accepted at this edge |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | 1 = hit, skip shading; 0 = shade this vertex |
| rsp_index | output | IDX_W | Index of the response |
| rsp_data | output | DATA_W | Stored attributes on a hit, zero on a miss |
| fill_valid | input | 1 | Shaded result present |
| fill_index | input | IDX_W | Vertex index of the shaded result |
| fill_data | input | DATA_W | Shaded attribute payload |

## Verification
A fill and a lookup can arrive in the same cycle, and so can a flush and a lookup. Both cases are provoked by driving the lookup together with `fill_valid` or `flush` and sampling `lk_ready` in that cycle. The fill case includes a lookup for the very index being filled. The results are judged by the stall, and then by whether the later lookup hits with the filled data or misses after the flush. The LRU order is judged against a timestamp model in the bench over a long pseudo-random index stream that oversubscribes the 32 entries.

// File: rtl/vtx_result_cache.sv
module vtx_result_cache #(
  parameter int N      = 32,
  parameter int IDX_W  = 16,
  parameter int DATA_W = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [IDX_W-1:0]  lk_index,
  output logic              lk_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_index,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_index,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int SW = $clog2(N);

  logic [N-1:0]      val_q, pend_q;
  logic [IDX_W-1:0]  tag_q [N];
  logic [DATA_W-1:0] dat_q [N];
  logic [SW-1:0]     age_q [N];

  logic [N-1:0] hit_vec, pm_vec, fm_vec;
  logic [SW-1:0] hit_id, fill_id, vic_id, touch_id, best;
  logic free_found, found;

  always_comb begin
    hit_id  = '0;
    fill_id = '0;
    for (int j = 0; j < N; j++) begin
      hit_vec[j] = val_q[j]  && tag_q[j] == lk_index;
      pm_vec[j]  = pend_q[j] && tag_q[j] == lk_index;
      fm_vec[j]  = pend_q[j] && tag_q[j] == fill_index;
      if (hit_vec[j]) hit_id  = SW'(j);
      if (fm_vec[j])  fill_id = SW'(j);
    end
  end

  always_comb begin
    vic_id     = '0;
    free_found = 1'b0;
    found      = 1'b0;
    best       = '0;
    for (int j = N - 1; j >= 0; j--)
      if (!val_q[j] && !pend_q[j]) begin
        vic_id     = SW'(j);
        free_found = 1'b1;
      end
    if (!free_found)
      for (int j = 0; j < N; j++)
        if (val_q[j] && !pend_q[j] && (!found || age_q[j] > best)) begin
          found  = 1'b1;
          best   = age_q[j];
          vic_id = SW'(j);
        end
  end

  wire lk_hit   = |hit_vec;
  wire vic_ok   = ~&pend_q;
  assign lk_ready = rst_n && !flush && !fill_valid && !(|pm_vec) && (lk_hit || vic_ok);
  wire accept   = lk_valid && lk_ready;
  wire fill_ok  = fill_valid && !flush && |fm_vec;
  wire touch_en = fill_ok || accept;
  assign touch_id = fill_ok ? fill_id : (lk_hit ? hit_id : vic_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q     <= '0;
      pend_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_index <= '0;
      rsp_data  <= '0;
      for (int j = 0; j < N; j++) age_q[j] <= SW'(j);
    end else begin
      rsp_valid <= accept;
      rsp_hit   <= accept && lk_hit;
      rsp_index <= lk_index;
      rsp_data  <= (accept && lk_hit) ? dat_q[hit_id] : '0;
      if (flush) begin
        val_q  <= '0;
        pend_q <= '0;
      end else if (fill_ok) begin
        val_q[fill_id]  <= 1'b1;
        pend_q[fill_id] <= 1'b0;
      end else if (accept && !lk_hit) begin
        val_q[vic_id]  <= 1'b0;
        pend_q[vic_id] <= 1'b1;
      end
      if (touch_en)
        for (int j = 0; j < N; j++)
          if (SW'(j) == touch_id)             age_q[j] <= '0;
          else if (age_q[j] < age_q[touch_id]) age_q[j] <= age_q[j] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) dat_q[fill_id] <= fill_data;
    if (accept && !lk_hit) tag_q[vic_id] <= lk_index;
  end
endmodule

// File: rtl/vtx_result_cache_chk.sv
module vtx_result_cache_chk #(
  parameter int N      = 32,
  parameter int DATA_W = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              fill_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_data,
  input logic [N-1:0]      val_q,
  input logic [N-1:0]      pend_q
);
  assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (val_q == '0 && pend_q == '0));
  assert_flush_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !lk_ready);
  assert_rsp_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);
  assert_no_rsp_without_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !rsp_valid);
  assert_miss_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_data == '0);
  assert_valid_pend_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q & pend_q) == '0);
  assert_fill_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !lk_ready);
  assert_hit_implies_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
endmodule

bind vtx_result_cache vtx_result_cache_chk #(.N(N), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .fill_valid(fill_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
  .val_q(val_q), .pend_q(pend_q));

// File: tb/test_vtx_result_cache.sv
`timescale 1ns/100ps
module test_vtx_result_cache;
  localparam int N = 32, IW = 16, DW = 96;
  logic clk = 0, rst_n = 0, flush = 0, lk_valid = 0, fill_valid = 0;
  logic [IW-1:0] lk_index = 0, fill_index = 0;
  logic [DW-1:0] fill_data = 0;
  logic lk_ready, rsp_valid, rsp_hit;
  logic [IW-1:0] rsp_index;
  logic [DW-1:0] rsp_data;
  int errs = 0, checks = 0, gen = 0;

  always #2.5 clk = ~clk;

  vtx_result_cache #(.N(N), .IDX_W(IW), .DATA_W(DW)) i_vtx_result_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_index(lk_index),
    .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_index(rsp_index),
    .rsp_data(rsp_data), .fill_valid(fill_valid), .fill_index(fill_index), .fill_data(fill_data));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic logic [DW-1:0] mk(input logic [IW-1:0] idx, input int g);
    return {idx, g[15:0], ~idx, g[15:0] + 16'h11, idx ^ 16'h5A5A, 16'hC0DE};
  endfunction

  task automatic lookup(input logic [IW-1:0] idx, output bit hit, output logic [DW-1:0] d);
    int n = 0;
    @(negedge clk);
    lk_valid = 1; lk_index = idx;
    #0.5;
    while (!lk_ready && n < 50) begin @(negedge clk); #0.5; n++; end
    if (!lk_ready) begin
      chk(0, "R2", "lookup never accepted", 0, 1);
      lk_valid = 0; hit = 0; d = 0;
    end else begin
      @(posedge clk); @(negedge clk);
      lk_valid = 0;
      hit = rsp_valid && rsp_hit; d = rsp_data;
      chk(rsp_valid && rsp_index == idx, "R2", "response valid/index", DW'(rsp_index), DW'(idx));
    end
  endtask

  task automatic fill(input logic [IW-1:0] idx, input logic [DW-1:0] d);
    @(negedge clk);
    fill_valid = 1; fill_index = idx; fill_data = d;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic probe_ready(input logic [IW-1:0] idx, input bit exp, input string req);
    @(negedge clk);
    lk_valid = 1; lk_index = idx; #0.5;
    chk(lk_ready == exp, req, "lk_ready", DW'(lk_ready), DW'(exp));
    lk_valid = 0; #0.5;
  endtask

  logic [IW-1:0] mtag [N];
  bit mval [N];
  int mtime [N];
  logic [DW-1:0] mdat [N];

  initial begin
    #(5.0 * 150000);
    chk(0, "R2", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    bit h; logic [DW-1:0] d, d7;
    repeat (3) @(negedge clk);
    rst_n = 1;

    lookup(7, h, d);
    chk(!h, "R1", "first lookup after reset misses", DW'(h), 0);
    chk(d == 0, "R3", "miss data zero", d, 0);
    d7 = mk(7, ++gen); fill(7, d7);
    lookup(7, h, d);
    chk(h && d == d7, "R2", "hit returns filled data", d, d7);

    lookup(9, h, d);
    chk(!h, "R3", "miss on 9", DW'(h), 0);
    probe_ready(9, 0, "R4");
    repeat (3) @(negedge clk);
    probe_ready(9, 0, "R4");
    @(negedge clk);
    fill_valid = 1; fill_index = 9; fill_data = mk(9, ++gen);
    lk_valid = 1; lk_index = 9; #0.5;
    chk(!lk_ready, "R8", "lookup stalled by same-cycle fill", DW'(lk_ready), 0);
    @(negedge clk); fill_valid = 0; #0.5;
    chk(lk_ready, "R4", "ready after fill done", DW'(lk_ready), 1);
    lk_valid = 0;
    lookup(9, h, d);
    chk(h && d == mk(9, gen), "R4", "hit after pending fill", d, mk(9, gen));

    @(negedge clk);
    fill_valid = 1; fill_index = 123; fill_data = mk(123, 1);
    lk_valid = 1; lk_index = 7; #0.5;
    chk(!lk_ready, "R8", "hit lookup stalled by fill", DW'(lk_ready), 0);
    @(negedge clk); fill_valid = 0; lk_valid = 0;
    lookup(123, h, d);
    chk(!h, "R5", "stray fill ignored", DW'(h), 0);
    fill(123, mk(123, ++gen));

    @(negedge clk);
    flush = 1; lk_valid = 1; lk_index = 7; #0.5;
    chk(!lk_ready, "R1", "lookup blocked during flush", DW'(lk_ready), 0);
    @(negedge clk); flush = 0; lk_valid = 0;
    lookup(7, h, d);
    chk(!h, "R1", "miss after flush", DW'(h), 0);
    fill(7, mk(7, ++gen));

    do_flush();
    for (int i = 0; i < N; i++) begin
      lookup(IW'(100 + i), h, d);
      chk(!h, "R6", "cold miss", DW'(h), 0);
      fill(IW'(100 + i), mk(IW'(100 + i), 1000 + i));
    end
    for (int i = 0; i < N; i++) begin
      lookup(IW'(100 + i), h, d);
      chk(h && d == mk(IW'(100 + i), 1000 + i), "R6", "all 32 resident", d, mk(IW'(100 + i), 1000 + i));
    end
    lookup(100, h, d);
    lookup(200, h, d);
    chk(!h, "R7", "new index misses", DW'(h), 0);
    fill(200, mk(200, 7));
    lookup(100, h, d);
    chk(h, "R7", "recently hit entry kept", DW'(h), 1);
    lookup(102, h, d);
    chk(h, "R7", "second oldest kept", DW'(h), 1);
    lookup(101, h, d);
    chk(!h, "R7", "oldest entry evicted", DW'(h), 0);
    fill(101, mk(101, 8));

    do_flush();
    for (int j = 0; j < N; j++) mval[j] = 0;
    begin
      int now = 0; int unsigned lcg = 32'h1234_5678;
      for (int k = 0; k < 900; k++) begin
        int slot; logic [IW-1:0] idx;
        lcg = lcg * 1664525 + 1013904223;
        idx = IW'((lcg >> 16) % 48);
        slot = -1;
        for (int j = 0; j < N; j++) if (mval[j] && mtag[j] == idx) slot = j;
        lookup(idx, h, d);
        if (slot >= 0) begin
          chk(h && d == mdat[slot], "R7", "model hit", d, mdat[slot]);
          mtime[slot] = now++;
        end else begin
          chk(!h, "R7", "model miss", DW'(h), 0);
          for (int j = N - 1; j >= 0; j--) if (!mval[j]) slot = j;
          if (slot < 0) begin
            slot = 0;
            for (int j = 1; j < N; j++) if (mtime[j] < mtime[slot]) slot = j;
          end
          gen++;
          mtag[slot] = idx; mval[slot] = 1; mtime[slot] = now++; mdat[slot] = mk(idx, gen);
          fill(idx, mdat[slot]);
        end
      end
    end

    do_flush();
    for (int i = 0; i < N; i++) begin
      lookup(IW'(300 + i), h, d);
      chk(!h, "R3", "reserve miss", DW'(h), 0);
    end
    probe_ready(400, 0, "R9");
    probe_ready(305, 0, "R4");
    fill(305, mk(305, 55));
    lookup(305, h, d);
    chk(h && d == mk(305, 55), "R4", "filled pending hit", d, mk(305, 55));
    probe_ready(400, 1, "R9");
    lookup(400, h, d);
    chk(!h, "R9", "miss after entry freed", DW'(h), 0);
    do_flush();

    report();
  end
endmodule